// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the opcode of an instruction, and its function field when the opcode is R-format, into the control word of a single-cycle datapath. The word holds destination-register select, ALU operand select, writeback source select, register write enable, memory read and write enables, branch enable, a 2-bit ALU operation class and a register-jump select. The decoder covers R-format arithmetic, load word, store word, branch-on-equal, jump-register and load-upper-immediate. Load-upper-immediate reuses the ALU shifter through ALU class 11 and needs no datapath change. Jump-register steers the next PC from register read port 1.

A fault-injection path sits after the decoder. It can force any one control output to a constant 0 or 1, so a bench can study the effect of a stuck control line. A small next-PC selector, fed by the control word after fault injection, shows at the ports how the control word moves the PC. The whole block is combinational. There is no data stream, so no port has a handshake.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Opcode 000000 with any function field other than 001000 gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=1, mem_read=0, mem_write=0, branch=0, alu_op=10, jump_reg=0.
- R2: Opcode 100011 (load word) gives reg_dst=0, alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1, mem_write=0, branch=0, alu_op=00 (add), jump_reg=0.
- R3: Opcode 101011 (store word) gives reg_dst=0, alu_src=1, mem_to_reg=1, reg_write=0, mem_read=0, mem_write=1, branch=0, alu_op=00 (add), jump_reg=0.
- R4: Opcode 000100 (branch-on-equal) gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=0, mem_read=0, mem_write=0, branch=1, alu_op=01 (subtract), jump_reg=0.
- R5: Opcode 000000 with function field 001000 (jump-register) gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=0, mem_read=0, mem_write=0, branch=0, alu_op=10, jump_reg=1.
- R6: Opcode 001111 (load-upper-immediate) gives reg_dst=0 (write to the rt register), alu_src=1, mem_to_reg=0, reg_write=1, mem_read=0, mem_write=0, branch=0, alu_op=11 (shift), jump_reg=0.
- R7: Any other opcode drives every control output to 0.
- R8: With fault_en=1 and fault_sel=k below 10, control bit k takes the value of fault_val and every other bit keeps its decoded value. The bit indices are 0 reg_dst, 1 alu_src, 2 mem_to_reg, 3 reg_write, 4 mem_read, 5 mem_write, 6 branch, 7 alu_op[0], 8 alu_op[1], 9 jump_reg.
- R9: With fault_en=0, or with fault_sel of 10 or more, fault injection has no effect on any output.
- R10: next_pc is reg_rd1 when jump_reg=1. Otherwise it is branch_target when branch=1 and alu_zero=1. Otherwise it is pc_plus4. The selector uses the control bits after fault injection.
- R11: For R-format, load word, store word and branch-on-equal, branch equals alu_op[0] and reg_dst equals the inverse of alu_src.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Function field, used only for opcode 000000 |
| fault_en | input | 1 | Enables the stuck-line injection |
| fault_sel | input | 4 | Index of the control bit to force |
| fault_val | input | 1 | Value the selected bit is forced to |
| pc_plus4 | input | ADDR_W | Sequential next PC |
| branch_target | input | ADDR_W | Taken-branch target |
| reg_rd1 | input | ADDR_W | Register read port 1, the jump-register target |
| alu_zero | input | 1 | ALU zero flag |
| reg_dst | output | 1 | 1 selects rd as the write register, 0 selects rt |
| alu_src | output | 1 | 1 selects the immediate as ALU operand B |
| mem_to_reg | output | 1 | 1 selects memory data for writeback |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch enable |
| alu_op | output | 2 | ALU operation class |
| jump_reg | output | 1 | Next PC from register read port 1 |
| next_pc | output | ADDR_W | Selected next PC |

## Verification
The bench builds the block with its default ADDR_W of 32. It uses three distinct address values, so each next-PC source can be told apart. The 4-bit fault selector reaches all ten control bits plus six unused codes, which brings the no-effect case of R9 within reach. A stuck-at-1 branch line on an R-format instruction with the zero flag raised shows the selector taking a wrong branch.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;
  localparam int NUM_CTRL = 10;
  localparam int SEL_W    = 4;

  localparam int B_REG_DST   = 0;
  localparam int B_ALU_SRC   = 1;
  localparam int B_MEM2REG   = 2;
  localparam int B_REG_WRITE = 3;
  localparam int B_MEM_READ  = 4;
  localparam int B_MEM_WRITE = 5;
  localparam int B_BRANCH    = 6;
  localparam int B_ALUOP0    = 7;
  localparam int B_ALUOP1    = 8;
  localparam int B_JUMP_REG  = 9;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] FN_JR    = 6'b001000;

  typedef logic [NUM_CTRL-1:0] ctrl_vec_t;
endpackage

// File: rtl/sc_ctrl_main_decode.sv
module sc_ctrl_main_decode
  import sc_ctrl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_vec_t  ctrl
);
  // bit order: jr aluop1 aluop0 br mw mr rw m2r as rd
  always_comb begin
    unique case (opcode)
      OP_RTYPE: ctrl = (funct == FN_JR) ? 10'b1_1000_0000_1 : 10'b0_1000_0100_1;
      OP_LW:    ctrl = 10'b0_0000_1111_0;
      OP_SW:    ctrl = 10'b0_0001_0011_0;
      OP_BEQ:   ctrl = 10'b0_0110_0000_1;
      OP_LUI:   ctrl = 10'b0_1100_0101_0;
      default:  ctrl = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(opcode)) begin
      p_mem_excl_r7: assert (!(ctrl[B_MEM_READ] && ctrl[B_MEM_WRITE]));
      p_jr_nowrite_r5: assert (!ctrl[B_JUMP_REG] || (!ctrl[B_REG_WRITE] && !ctrl[B_MEM_WRITE] && !ctrl[B_BRANCH]));
      if (opcode == OP_RTYPE || opcode == OP_LW || opcode == OP_SW || opcode == OP_BEQ) begin
        p_branch_eq_aluop0_r11: assert (ctrl[B_BRANCH] == ctrl[B_ALUOP0]);
        p_regdst_inv_alusrc_r11: assert (ctrl[B_REG_DST] == !ctrl[B_ALU_SRC]);
      end
      if (opcode == OP_LUI)
        p_lui_rt_dest_r6: assert (!ctrl[B_REG_DST] && ctrl[B_REG_WRITE]);
    end
  end
endmodule

// File: rtl/sc_ctrl_fault_inject.sv
module sc_ctrl_fault_inject
  import sc_ctrl_pkg::*;
(
  input  ctrl_vec_t        ctrl_in,
  input  logic             fault_en,
  input  logic [SEL_W-1:0] fault_sel,
  input  logic             fault_val,
  output ctrl_vec_t        ctrl_out
);
  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_bit
    assign ctrl_out[i] = (fault_en && fault_sel == SEL_W'(i)) ? fault_val : ctrl_in[i];
  end

  always_comb begin
    if (!$isunknown({ctrl_in, fault_en, fault_sel, fault_val})) begin
      p_single_line_r8: assert ($countones(ctrl_out ^ ctrl_in) <= 1);
      if (!fault_en)
        p_off_passthru_r9: assert (ctrl_out == ctrl_in);
    end
  end
endmodule

// File: rtl/sc_ctrl_next_pc.sv
module sc_ctrl_next_pc #(
  parameter int ADDR_W = 32
) (
  input  logic              jump_reg,
  input  logic              branch,
  input  logic              alu_zero,
  input  logic [ADDR_W-1:0] pc_plus4,
  input  logic [ADDR_W-1:0] branch_target,
  input  logic [ADDR_W-1:0] reg_rd1,
  output logic [ADDR_W-1:0] next_pc
);
  logic              take_br;
  logic [ADDR_W-1:0] seq_or_br;

  assign take_br   = branch & alu_zero;
  assign seq_or_br = take_br ? branch_target : pc_plus4;
  assign next_pc   = jump_reg ? reg_rd1 : seq_or_br;

  always_comb begin
    if (!$isunknown({jump_reg, branch, alu_zero}))
      p_pc_source_r10: assert (next_pc == pc_plus4 || next_pc == branch_target || next_pc == reg_rd1);
  end
endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import sc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [5:0]        opcode,
  input  logic [5:0]        funct,
  input  logic              fault_en,
  input  logic [3:0]        fault_sel,
  input  logic              fault_val,
  input  logic [ADDR_W-1:0] pc_plus4,
  input  logic [ADDR_W-1:0] branch_target,
  input  logic [ADDR_W-1:0] reg_rd1,
  input  logic              alu_zero,
  output logic              reg_dst,
  output logic              alu_src,
  output logic              mem_to_reg,
  output logic              reg_write,
  output logic              mem_read,
  output logic              mem_write,
  output logic              branch,
  output logic [1:0]        alu_op,
  output logic              jump_reg,
  output logic [ADDR_W-1:0] next_pc
);
  ctrl_vec_t raw_ctrl;
  ctrl_vec_t ctrl;

  sc_ctrl_main_decode i_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (raw_ctrl)
  );

  sc_ctrl_fault_inject i_flt (
    .ctrl_in   (raw_ctrl),
    .fault_en  (fault_en),
    .fault_sel (fault_sel),
    .fault_val (fault_val),
    .ctrl_out  (ctrl)
  );

  assign reg_dst    = ctrl[B_REG_DST];
  assign alu_src    = ctrl[B_ALU_SRC];
  assign mem_to_reg = ctrl[B_MEM2REG];
  assign reg_write  = ctrl[B_REG_WRITE];
  assign mem_read   = ctrl[B_MEM_READ];
  assign mem_write  = ctrl[B_MEM_WRITE];
  assign branch     = ctrl[B_BRANCH];
  assign alu_op     = {ctrl[B_ALUOP1], ctrl[B_ALUOP0]};
  assign jump_reg   = ctrl[B_JUMP_REG];

  sc_ctrl_next_pc #(.ADDR_W(ADDR_W)) i_npc (
    .jump_reg      (jump_reg),
    .branch        (branch),
    .alu_zero      (alu_zero),
    .pc_plus4      (pc_plus4),
    .branch_target (branch_target),
    .reg_rd1       (reg_rd1),
    .next_pc       (next_pc)
  );
endmodule

// File: tb/test_sc_ctrl_decoder.sv
module test_sc_ctrl_decoder;
  localparam int AW = 32;
  localparam logic [AW-1:0] PC4 = 32'h0000_1004;
  localparam logic [AW-1:0] BTG = 32'h0000_2000;
  localparam logic [AW-1:0] RD1 = 32'h0000_3ABC;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic [5:0] opcode = 0, funct = 0;
  logic fault_en = 0, fault_val = 0, alu_zero = 0;
  logic [3:0] fault_sel = 0;
  logic [AW-1:0] pc_plus4 = PC4, branch_target = BTG, reg_rd1 = RD1;
  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump_reg;
  logic [1:0] alu_op;
  logic [AW-1:0] next_pc;

  int n_checks = 0;
  int n_fail = 0;

  sc_ctrl_decoder #(.ADDR_W(AW)) i_sc_ctrl_decoder (
    .opcode(opcode), .funct(funct), .fault_en(fault_en), .fault_sel(fault_sel),
    .fault_val(fault_val), .pc_plus4(pc_plus4), .branch_target(branch_target),
    .reg_rd1(reg_rd1), .alu_zero(alu_zero), .reg_dst(reg_dst), .alu_src(alu_src),
    .mem_to_reg(mem_to_reg), .reg_write(reg_write), .mem_read(mem_read),
    .mem_write(mem_write), .branch(branch), .alu_op(alu_op), .jump_reg(jump_reg),
    .next_pc(next_pc)
  );

  // order: jr aluop1 aluop0 branch mw mr rw m2r alusrc regdst
  function automatic logic [9:0] exp_ctrl(input logic [5:0] op, input logic [5:0] fn);
    logic rd, as, m2r, rw, mr, mw, br, jr;
    logic [1:0] ao;
    {rd, as, m2r, rw, mr, mw, br, ao, jr} = '0;
    case (op)
      6'b000000: begin rd = 1; ao = 2'b10;
                   if (fn == 6'b001000) jr = 1; else rw = 1; end
      6'b100011: begin as = 1; m2r = 1; rw = 1; mr = 1; end
      6'b101011: begin as = 1; m2r = 1; mw = 1; end
      6'b000100: begin rd = 1; br = 1; ao = 2'b01; end
      6'b001111: begin as = 1; rw = 1; ao = 2'b11; end
      default: ;
    endcase
    return {jr, ao, br, mw, mr, rw, m2r, as, rd};
  endfunction

  function automatic logic [9:0] got_ctrl();
    return {jump_reg, alu_op, branch, mem_write, mem_read, reg_write, mem_to_reg, alu_src, reg_dst};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    opcode = op; funct = fn;
    #1;
  endtask

  task automatic check_vec(input string tag, input logic [9:0] exp);
    n_checks++;
    if (got_ctrl() !== exp) begin
      n_fail++;
      $display("FAIL %s: ctrl actual %b expected %b", tag, got_ctrl(), exp);
    end
  endtask

  task automatic check_pc(input string tag, input logic [AW-1:0] exp);
    n_checks++;
    if (next_pc !== exp) begin
      n_fail++;
      $display("FAIL %s: next_pc actual %h expected %h", tag, next_pc, exp);
    end
  endtask

  task automatic t_reset_state();
    check_vec("R1 reset-state rtype", exp_ctrl(6'b000000, 6'b000000));
  endtask

  task automatic t_rtype();
    logic [5:0] fns[3] = '{6'b100000, 6'b100010, 6'b101010};
    foreach (fns[i]) begin
      apply(6'b000000, fns[i]);
      check_vec("R1 rtype", exp_ctrl(6'b000000, fns[i]));
    end
    alu_zero = 1; #1;
    check_pc("R10 rtype zero no branch", PC4);
    alu_zero = 0;
  endtask

  task automatic t_lw_sw();
    apply(6'b100011, 6'b111111);
    check_vec("R2 lw", exp_ctrl(6'b100011, 0));
    apply(6'b101011, 6'b001000);
    check_vec("R3 sw", exp_ctrl(6'b101011, 0));
    if (branch !== alu_op[0] || reg_dst !== !alu_src) begin
      n_checks++; n_fail++;
      $display("FAIL R11 sw invariant: br=%b aop0=%b rd=%b as=%b expected br==aop0, rd==!as", branch, alu_op[0], reg_dst, alu_src);
    end else n_checks++;
  endtask

  task automatic t_beq();
    apply(6'b000100, 0);
    check_vec("R4 beq", exp_ctrl(6'b000100, 0));
    alu_zero = 0; #1; check_pc("R10 beq not taken", PC4);
    alu_zero = 1; #1; check_pc("R10 beq taken", BTG);
    alu_zero = 0;
  endtask

  task automatic t_jr();
    apply(6'b000000, 6'b001000);
    check_vec("R5 jr", exp_ctrl(6'b000000, 6'b001000));
    check_pc("R10 jr target", RD1);
  endtask

  task automatic t_lui();
    apply(6'b001111, 6'b000000);
    check_vec("R6 lui", exp_ctrl(6'b001111, 0));
    check_pc("R10 lui sequential", PC4);
  endtask

  task automatic t_unknown();
    logic [5:0] ops[4] = '{6'b000010, 6'b111111, 6'b001000, 6'b100000};
    foreach (ops[i]) begin
      apply(ops[i], 6'b001000);
      check_vec("R7 unknown opcode", 10'b0);
    end
  endtask

  task automatic t_fault();
    logic [9:0] e;
    fault_en = 1; fault_val = 0; fault_sel = 4'd3;
    apply(6'b000000, 6'b100000);
    e = exp_ctrl(6'b000000, 6'b100000); e[3] = 0;
    check_vec("R8 rtype regwrite stuck0", e);
    apply(6'b100011, 0);
    e = exp_ctrl(6'b100011, 0); e[3] = 0;
    check_vec("R8 lw regwrite stuck0", e);
    for (int k = 0; k < 10; k++) begin
      fault_sel = 4'(k); fault_val = 1;
      apply(6'b000100, 0);
      e = exp_ctrl(6'b000100, 0); e[k] = 1;
      check_vec("R8 beq stuck1 sweep", e);
    end
    fault_sel = 4'd6; fault_val = 1; alu_zero = 1;
    apply(6'b000000, 6'b100000);
    check_pc("R8 R10 stuck branch takes branch", BTG);
    fault_val = 0;
    apply(6'b000100, 0);
    check_pc("R8 R10 stuck0 branch never taken", PC4);
    alu_zero = 0;
    fault_sel = 4'd9; fault_val = 1;
    apply(6'b100011, 0);
    check_pc("R8 R10 stuck jump_reg", RD1);
  endtask

  task automatic t_fault_inert();
    for (int s = 10; s < 16; s++) begin
      fault_en = 1; fault_sel = 4'(s); fault_val = 1;
      apply(6'b101011, 0);
      check_vec("R9 unused selector", exp_ctrl(6'b101011, 0));
    end
    fault_en = 0; fault_sel = 4'd5; fault_val = 0;
    apply(6'b101011, 0);
    check_vec("R9 disabled", exp_ctrl(6'b101011, 0));
    fault_sel = 4'd3; fault_val = 1;
    apply(6'b000100, 0);
    check_vec("R9 disabled beq", exp_ctrl(6'b000100, 0));
  endtask

  initial begin : watchdog
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1;
    #1;
    t_reset_state();
    t_rtype();
    t_lw_sw();
    t_beq();
    t_jr();
    t_lui();
    t_unknown();
    t_fault();
    t_fault_inert();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule